// File: doc/BRIEF.md
# SPI Configuration Register Slave

This block is a serial-port slave that keeps the control settings of a dual-channel (I and Q) data converter in four 8-bit registers. A host frames each access with an active-low chip select and sends an instruction word followed by exactly one data byte. The first instruction bit marks the access as a read or a write. Write data is stored in the addressed register. Read data is shifted back on the output line during the data byte. Every control field is decoded onto its own output pin, covering power, input data format and data-clock routing.

The serial pins are sampled by the block's system clock through synchronizers, so the serial clock must be well below the system clock. Two settings in register 0 change the framing while the block runs: the shift order of both instruction and data, and the instruction address length (5 or 13 bits). A soft-reset bit in the same register forces registers 1 to 3 back to their defaults and holds them there until the bit is written back to 0. Register 0 keeps its own contents during a soft reset. Global power-down is only a decoded output, so the serial port keeps working while it is set.

Top module: `spicfg_slave`

## Requirements
- R1: In short-address mode (register 0 bit 4 = 0) with MSB-first order (register 0 bit 6 = 0), a transfer is an 8-bit instruction followed by 8 data bits, each sent most significant bit first. The instruction is: bit 7 = access type (1 read, 0 write), bits 6:5 = reserved (send 0), bits 4:0 = address. A write stores the data byte, masked to the defined bits, in the addressed register. Data is sampled on rising serial-clock edges.
- R2: In a read, the slave drives each data bit on the serial-clock falling edge that comes before the rising edge where the host samples it. The data returned is the stored value of every defined bit, and undefined bits read 0. A read changes no register.
- R3: When register 0 bit 6 = 1, the whole instruction word and the data byte of the following transfers are sent and returned least significant bit first, so the access-type bit is the last instruction bit.
- R4: When register 0 bit 4 = 1, the following transfers use a 16-bit instruction: bit 15 = access type, bits 14:13 = reserved, bits 12:0 = address. Address 0x1003 is unmapped and does not alias register 3.
- R5: Writing 1 to register 0 bit 5 restores registers 1 to 3 to their defaults and holds them there. Writes to them are ignored until a write clears bit 5. Register 0 reads back its written value throughout.
- R6: After the hardware reset input, the registers read back as follows: register 0 = 0x00, register 1 = 0x40, register 2 = 0x34, register 3 = 0x00.
- R7: Register 1 bit 6 is a read-only status bit. It reads as the inverse of register 1 bit 7 (the regulator-off control), and writes to it have no effect.
- R8: Addresses 4 and above read as 0x00, and writes to them change no register.
- R9: Raising chip select before the data byte is complete aborts the transfer: nothing is written, and the next transfer is framed from its first instruction bit.
- R10: Setting register 1 bit 5 (global power-down) drives the power-down output high, and register reads and writes keep working.
- R11: Output mapping. Register 1 bits 7, 5, 4, 3, 2, 1, 0 drive regulator off, power-down, Q output off, I output off, Q clock off, I clock off and external reference. Register 2 bits 7, 5, 4, 3, 2, 1, 0 drive twos-complement format, I-first pairing, I-on-rising latch, shared data-clock pin block, data-clock input enable, single-strength clock output and double-strength clock output. Register 3 bits 5:0 drive the fine gain code. Register 2 bit 6 and register 3 bits 7:6 are undefined.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock; samples the serial pins |
| rst_n | input | 1 | Asynchronous active-low reset |
| spi_cs_n | input | 1 | Active-low chip select |
| spi_sclk | input | 1 | Serial clock from the host |
| spi_mosi | input | 1 | Serial data from the host |
| spi_miso | output | 1 | Serial readback data to the host |
| ldo_off | output | 1 | Core regulator off |
| pwr_down | output | 1 | Global power-down |
| q_out_off | output | 1 | Q channel output current off |
| i_out_off | output | 1 | I channel output current off |
| q_clk_off | output | 1 | Q channel clock off |
| i_clk_off | output | 1 | I channel clock off |
| ext_ref_sel | output | 1 | Internal reference off, external reference used |
| fmt_twos | output | 1 | Input data is twos complement |
| pair_i_first | output | 1 | I sample comes first in each input pair |
| latch_i_rising | output | 1 | I data is latched on the rising data-clock edge |
| dclk_share_block | output | 1 | Blocks simultaneous input and output use of the data-clock pin |
| dclk_in_en | output | 1 | Data-clock input enable |
| dclk_out_single | output | 1 | Data-clock output, single drive strength |
| dclk_out_double | output | 1 | Data-clock output, added parallel driver |
| fine_gain | output | 6 | I channel fine gain code |

## Verification
The assertions assume the serial clock is slow against the system clock: each serial-clock level lasts several system clocks, so every edge reaches the transfer logic as exactly one sampled event. They also assume data and chip-select changes settle before the next synchronized edge. The stimulus holds each serial-clock level for eight system clocks. It changes the data line only right after a falling edge, and it moves chip select only while the serial clock is low. Each shift-order or address-length change is written as a complete transfer of its own, so each mode takes effect only from the next transfer.

// File: rtl/spicfg_pkg.sv
package spicfg_pkg;
    localparam int DATA_W     = 8;
    localparam int ADDR_W     = 13;
    localparam int SHORT_AW   = 5;
    localparam int INSTR_W    = 16;
    localparam int NUM_REGS   = 4;
    localparam int CNT_W      = $clog2(INSTR_W) + 1;
    localparam int FCNT_W     = $clog2(DATA_W) + 1;

    localparam int CTL_LSB_FIRST = 6;
    localparam int CTL_SOFT_RST  = 5;
    localparam int CTL_LONG_ADDR = 4;
    localparam int PWR_LDO_OFF   = 7;

    localparam logic [DATA_W-1:0] CTL_MASK  = 8'h70;
    localparam logic [DATA_W-1:0] PWR_MASK  = 8'hBF;
    localparam logic [DATA_W-1:0] FMT_MASK  = 8'hBF;
    localparam logic [DATA_W-1:0] GAIN_MASK = 8'h3F;
    localparam logic [DATA_W-1:0] PWR_DEF   = 8'h00;
    localparam logic [DATA_W-1:0] FMT_DEF   = 8'h34;
    localparam logic [DATA_W-1:0] GAIN_DEF  = 8'h00;

    typedef enum logic [1:0] {PH_INSTR, PH_DATA, PH_DONE} phase_e;

    typedef struct packed {
        phase_e              phase;
        logic [CNT_W-1:0]    cnt;
        logic [FCNT_W-1:0]   fcnt;
        logic [INSTR_W-1:0]  instr;
        logic [DATA_W-1:0]   data;
        logic                miso;
        logic                wr_stb;
        logic                sclk_prev;
    } xfer_t;

    typedef struct packed {
        logic [DATA_W-1:0] ctl;
        logic [DATA_W-1:0] pwr;
        logic [DATA_W-1:0] fmt;
        logic [DATA_W-1:0] gain;
    } regs_t;
endpackage

// File: rtl/spicfg_sync.sv
module spicfg_sync #(
    parameter int               WIDTH   = 3,
    parameter int               STAGES  = 2,
    parameter logic [WIDTH-1:0] RST_VAL = '0
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic [WIDTH-1:0] din,
    output logic [WIDTH-1:0] dout
);
    generate
        for (genvar i = 0; i < WIDTH; i++) begin : g_bit
            logic [STAGES-1:0] chain_d, chain_q;
            always_comb chain_d = {chain_q[STAGES-2:0], din[i]};
            always_ff @(posedge clk or negedge rst_n) begin
                if (!rst_n) chain_q <= {STAGES{RST_VAL[i]}};
                else        chain_q <= chain_d;
            end
            assign dout[i] = chain_q[STAGES-1];
        end
    endgenerate
endmodule

// File: rtl/spicfg_xfer.sv
module spicfg_xfer
    import spicfg_pkg::*;
(
    input  logic              clk,
    input  logic              rst_n,
    input  logic              cs_n,
    input  logic              sclk,
    input  logic              mosi,
    input  logic              lsb_first,
    input  logic              long_addr,
    input  logic [DATA_W-1:0] rd_data,
    output logic [ADDR_W-1:0] addr,
    output logic              wr_en,
    output logic [DATA_W-1:0] wr_data,
    output logic              miso
);
    xfer_t q, d;

    logic             rise, fall, is_read;
    logic [CNT_W-1:0] ilen, idx;
    logic [2:0]       bsel;

    assign is_read = long_addr ? q.instr[INSTR_W-1] : q.instr[DATA_W-1];
    assign addr    = long_addr ? q.instr[ADDR_W-1:0]
                               : {{(ADDR_W-SHORT_AW){1'b0}}, q.instr[SHORT_AW-1:0]};

    always_comb begin
        d           = q;
        d.wr_stb    = 1'b0;
        d.sclk_prev = sclk;
        rise        = sclk & ~q.sclk_prev;
        fall        = ~sclk & q.sclk_prev;
        ilen        = long_addr ? CNT_W'(INSTR_W) : CNT_W'(DATA_W);
        idx         = '0;
        bsel        = '0;
        if (cs_n) begin
            d.phase = PH_INSTR;
            d.cnt   = '0;
            d.fcnt  = '0;
            d.instr = '0;
            d.data  = '0;
            d.miso  = 1'b0;
        end else begin
            case (q.phase)
                PH_INSTR: if (rise) begin
                    idx = lsb_first ? q.cnt : (ilen - CNT_W'(1) - q.cnt);
                    d.instr[idx[CNT_W-2:0]] = mosi;
                    if (q.cnt == ilen - CNT_W'(1)) begin
                        d.phase = PH_DATA;
                        d.cnt   = '0;
                        d.fcnt  = '0;
                    end else begin
                        d.cnt = q.cnt + CNT_W'(1);
                    end
                end
                PH_DATA: begin
                    if (rise) begin
                        bsel = lsb_first ? q.cnt[2:0] : 3'd7 - q.cnt[2:0];
                        d.data[bsel] = mosi;
                        if (q.cnt == CNT_W'(DATA_W - 1)) begin
                            d.phase  = PH_DONE;
                            d.wr_stb = ~is_read;
                        end else begin
                            d.cnt = q.cnt + CNT_W'(1);
                        end
                    end
                    if (fall && is_read && q.fcnt < FCNT_W'(DATA_W)) begin
                        d.miso = rd_data[lsb_first ? q.fcnt[2:0] : 3'd7 - q.fcnt[2:0]];
                        d.fcnt = q.fcnt + FCNT_W'(1);
                    end
                end
                default: ;
            endcase
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            q           <= '0;
            q.phase     <= PH_INSTR;
        end else begin
            q <= d;
        end
    end

    assign wr_en   = q.wr_stb;
    assign wr_data = q.data;
    assign miso    = q.miso;

    // R9
    cs_abort_chk: assert property (@(posedge clk) disable iff (!rst_n)
        cs_n |=> (q.phase == PH_INSTR && !q.miso && q.cnt == '0));
    // R1
    wr_single_chk: assert property (@(posedge clk) disable iff (!rst_n)
        q.wr_stb |=> !q.wr_stb);
    // R2
    rd_nowrite_chk: assert property (@(posedge clk) disable iff (!rst_n)
        q.wr_stb |-> (q.phase == PH_DONE && !is_read));
endmodule

// File: rtl/spicfg_regs.sv
module spicfg_regs
    import spicfg_pkg::*;
(
    input  logic              clk,
    input  logic              rst_n,
    input  logic              wr_en,
    input  logic [ADDR_W-1:0] addr,
    input  logic [DATA_W-1:0] wr_data,
    output logic [DATA_W-1:0] rd_data,
    output regs_t             regs
);
    regs_t q, d;

    always_comb begin
        d = q;
        if (wr_en) begin
            case (addr)
                ADDR_W'(0): d.ctl  = wr_data & CTL_MASK;
                ADDR_W'(1): d.pwr  = wr_data & PWR_MASK;
                ADDR_W'(2): d.fmt  = wr_data & FMT_MASK;
                ADDR_W'(3): d.gain = wr_data & GAIN_MASK;
                default: ;
            endcase
        end
        if (d.ctl[CTL_SOFT_RST]) begin
            d.pwr  = PWR_DEF;
            d.fmt  = FMT_DEF;
            d.gain = GAIN_DEF;
        end
    end

    always_comb begin
        case (addr)
            ADDR_W'(0): rd_data = q.ctl;
            ADDR_W'(1): rd_data = {q.pwr[PWR_LDO_OFF], ~q.pwr[PWR_LDO_OFF], q.pwr[5:0]};
            ADDR_W'(2): rd_data = q.fmt;
            ADDR_W'(3): rd_data = q.gain;
            default:    rd_data = '0;
        endcase
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            q.ctl  <= '0;
            q.pwr  <= PWR_DEF;
            q.fmt  <= FMT_DEF;
            q.gain <= GAIN_DEF;
        end else begin
            q <= d;
        end
    end

    assign regs = q;

    // R5
    hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (q.ctl[CTL_SOFT_RST] && wr_en && addr == ADDR_W'(3)) |=> (q.gain == GAIN_DEF));
    // R5
    restore_chk: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(q.ctl[CTL_SOFT_RST]) |-> (q.fmt == FMT_DEF && q.pwr == PWR_DEF));
    // R8
    unmapped_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (wr_en && addr >= ADDR_W'(NUM_REGS)) |=> $stable(q));
    // R7
    status_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (addr == ADDR_W'(1)) |-> (rd_data[6] != q.pwr[PWR_LDO_OFF]));
endmodule

// File: rtl/spicfg_slave.sv
module spicfg_slave
    import spicfg_pkg::*;
#(
    parameter int SYNC_STAGES = 2
) (
    input  logic       clk,
    input  logic       rst_n,
    input  logic       spi_cs_n,
    input  logic       spi_sclk,
    input  logic       spi_mosi,
    output logic       spi_miso,
    output logic       ldo_off,
    output logic       pwr_down,
    output logic       q_out_off,
    output logic       i_out_off,
    output logic       q_clk_off,
    output logic       i_clk_off,
    output logic       ext_ref_sel,
    output logic       fmt_twos,
    output logic       pair_i_first,
    output logic       latch_i_rising,
    output logic       dclk_share_block,
    output logic       dclk_in_en,
    output logic       dclk_out_single,
    output logic       dclk_out_double,
    output logic [5:0] fine_gain
);
    logic [2:0]        pins_s;
    logic [ADDR_W-1:0] addr;
    logic              wr_en;
    logic [DATA_W-1:0] wr_data, rd_data;
    regs_t             regs;

    spicfg_sync #(.WIDTH(3), .STAGES(SYNC_STAGES), .RST_VAL(3'b100)) u_sync (
        .clk(clk), .rst_n(rst_n),
        .din({spi_cs_n, spi_sclk, spi_mosi}),
        .dout(pins_s)
    );

    spicfg_xfer u_xfer (
        .clk(clk), .rst_n(rst_n),
        .cs_n(pins_s[2]), .sclk(pins_s[1]), .mosi(pins_s[0]),
        .lsb_first(regs.ctl[CTL_LSB_FIRST]),
        .long_addr(regs.ctl[CTL_LONG_ADDR]),
        .rd_data(rd_data), .addr(addr),
        .wr_en(wr_en), .wr_data(wr_data), .miso(spi_miso)
    );

    spicfg_regs u_regs (
        .clk(clk), .rst_n(rst_n),
        .wr_en(wr_en), .addr(addr), .wr_data(wr_data),
        .rd_data(rd_data), .regs(regs)
    );

    assign ldo_off          = regs.pwr[7];
    assign pwr_down         = regs.pwr[5];
    assign q_out_off        = regs.pwr[4];
    assign i_out_off        = regs.pwr[3];
    assign q_clk_off        = regs.pwr[2];
    assign i_clk_off        = regs.pwr[1];
    assign ext_ref_sel      = regs.pwr[0];
    assign fmt_twos         = regs.fmt[7];
    assign pair_i_first     = regs.fmt[5];
    assign latch_i_rising   = regs.fmt[4];
    assign dclk_share_block = regs.fmt[3];
    assign dclk_in_en       = regs.fmt[2];
    assign dclk_out_single  = regs.fmt[1];
    assign dclk_out_double  = regs.fmt[0];
    assign fine_gain        = regs.gain[5:0];
endmodule

// File: tb/sim_spicfg_slave.sv
module sim_spicfg_slave;
    logic clk = 1'b0, rst_n = 1'b0;
    logic cs_n = 1'b1, sclk = 1'b0, mosi = 1'b0;
    logic miso, ldo_off, pwr_down, q_out_off, i_out_off, q_clk_off, i_clk_off, ext_ref_sel;
    logic fmt_twos, pair_i_first, latch_i_rising, dclk_share_block, dclk_in_en;
    logic dclk_out_single, dclk_out_double;
    logic [5:0] fine_gain;

    int checks = 0, errors = 0;
    bit finished = 0;
    logic cur_lsb = 1'b0, cur_long = 1'b0;

    always #5 clk = ~clk;

    spicfg_slave u0 (
        .clk(clk), .rst_n(rst_n), .spi_cs_n(cs_n), .spi_sclk(sclk), .spi_mosi(mosi),
        .spi_miso(miso), .ldo_off(ldo_off), .pwr_down(pwr_down), .q_out_off(q_out_off),
        .i_out_off(i_out_off), .q_clk_off(q_clk_off), .i_clk_off(i_clk_off),
        .ext_ref_sel(ext_ref_sel), .fmt_twos(fmt_twos), .pair_i_first(pair_i_first),
        .latch_i_rising(latch_i_rising), .dclk_share_block(dclk_share_block),
        .dclk_in_en(dclk_in_en), .dclk_out_single(dclk_out_single),
        .dclk_out_double(dclk_out_double), .fine_gain(fine_gain)
    );

    task automatic half();
        repeat (8) @(negedge clk);
    endtask

    task automatic chk(input string req, input logic [7:0] act, input logic [7:0] exp);
        checks++;
        if (act !== exp) begin
            errors++;
            $display("FAIL %s: got 0x%02h expected 0x%02h", req, act, exp);
        end
    endtask

    task automatic send_instr(input logic rw, input logic [12:0] addr);
        logic [15:0] w;
        int ilen;
        ilen = cur_long ? 16 : 8;
        w = cur_long ? {rw, 2'b00, addr} : {8'h00, rw, 2'b00, addr[4:0]};
        cs_n = 1'b0;
        half();
        for (int i = 0; i < ilen; i++) begin
            mosi = cur_lsb ? w[i] : w[ilen-1-i];
            half(); sclk = 1'b1; half(); sclk = 1'b0;
        end
    endtask

    task automatic xfer(input logic rw, input logic [12:0] addr, input logic [7:0] wd,
                        output logic [7:0] rd);
        send_instr(rw, addr);
        for (int i = 0; i < 8; i++) begin
            mosi = cur_lsb ? wd[i] : wd[7-i];
            half();
            if (cur_lsb) rd[i] = miso; else rd[7-i] = miso;
            sclk = 1'b1; half(); sclk = 1'b0;
        end
        half(); cs_n = 1'b1; half();
    endtask

    task automatic wr(input logic [12:0] a, input logic [7:0] v);
        logic [7:0] dummy;
        xfer(1'b0, a, v, dummy);
    endtask

    task automatic rd(input logic [12:0] a, output logic [7:0] v);
        xfer(1'b1, a, 8'h00, v);
    endtask

    task automatic t_reset();
        logic [7:0] v;
        chk("R6 outputs pwr", {ldo_off, pwr_down, q_out_off, i_out_off, q_clk_off, i_clk_off, ext_ref_sel, 1'b0}, 8'h00);
        chk("R6 outputs fmt", {fmt_twos, pair_i_first, latch_i_rising, dclk_share_block, dclk_in_en, dclk_out_single, dclk_out_double, 1'b0}, 8'b0110_1000);
        chk("R6 gain", {2'b00, fine_gain}, 8'h00);
        rd(13'd0, v); chk("R6 reg0", v, 8'h00);
        rd(13'd1, v); chk("R6 reg1", v, 8'h40);
        rd(13'd2, v); chk("R6 reg2", v, 8'h34);
        rd(13'd3, v); chk("R6 reg3", v, 8'h00);
    endtask

    task automatic t_write_read();
        logic [7:0] v;
        wr(13'd3, 8'hE5); rd(13'd3, v); chk("R2 reg3 masked", v, 8'h25);
        chk("R11 fine_gain", {2'b00, fine_gain}, 8'h25);
        wr(13'd2, 8'hCB); rd(13'd2, v); chk("R1 reg2 write", v, 8'h8B);
        chk("R11 fmt outputs", {fmt_twos, pair_i_first, latch_i_rising, dclk_share_block, dclk_in_en, dclk_out_single, dclk_out_double, 1'b0}, 8'b1001_0110);
        wr(13'd1, 8'h1F); rd(13'd1, v); chk("R1 reg1 write", v, 8'h5F);
        chk("R11 pwr outputs", {ldo_off, pwr_down, q_out_off, i_out_off, q_clk_off, i_clk_off, ext_ref_sel, 1'b0}, 8'b0011_1110);
        rd(13'd2, v); chk("R2 read leaves reg2", v, 8'h8B);
        wr(13'd1, 8'h00);
    endtask

    task automatic t_status();
        logic [7:0] v;
        wr(13'd1, 8'hC0); rd(13'd1, v); chk("R7 ldo off status", v, 8'h80);
        chk("R7 ldo_off pin", {7'd0, ldo_off}, 8'h01);
        wr(13'd1, 8'h3F); rd(13'd1, v); chk("R7 ldo on status", v, 8'h7F);
        wr(13'd1, 8'h00);
    endtask

    task automatic t_unmapped();
        logic [7:0] v;
        wr(13'd5, 8'hFF); rd(13'd5, v); chk("R8 unmapped read", v, 8'h00);
        rd(13'd3, v); chk("R8 reg3 unchanged", v, 8'h25);
        rd(13'd0, v); chk("R8 reg0 unchanged", v, 8'h00);
    endtask

    task automatic t_lsb();
        logic [7:0] v;
        wr(13'd0, 8'h40); cur_lsb = 1'b1;
        wr(13'd2, 8'h83); rd(13'd2, v); chk("R3 lsb-first reg2", v, 8'h83);
        chk("R3 lsb-first outputs", {fmt_twos, dclk_out_single, dclk_out_double, 5'd0}, 8'hE0);
        rd(13'd0, v); chk("R3 reg0 readback", v, 8'h40);
        wr(13'd0, 8'h00); cur_lsb = 1'b0;
        rd(13'd3, v); chk("R3 back to msb-first", v, 8'h25);
    endtask

    task automatic t_long();
        logic [7:0] v;
        wr(13'd0, 8'h10); cur_long = 1'b1;
        wr(13'd3, 8'h2A); rd(13'd3, v); chk("R4 long reg3", v, 8'h2A);
        wr(13'h1003, 8'h15); rd(13'd3, v); chk("R4 no alias", v, 8'h2A);
        rd(13'h1003, v); chk("R4 unmapped long read", v, 8'h00);
        wr(13'd0, 8'h00); cur_long = 1'b0;
        rd(13'd3, v); chk("R4 back to short", v, 8'h2A);
    endtask

    task automatic t_softreset();
        logic [7:0] v;
        wr(13'd3, 8'h11); wr(13'd2, 8'h80);
        wr(13'd0, 8'h20);
        rd(13'd3, v); chk("R5 reg3 default", v, 8'h00);
        rd(13'd2, v); chk("R5 reg2 default", v, 8'h34);
        rd(13'd0, v); chk("R5 reg0 kept", v, 8'h20);
        wr(13'd3, 8'h05); rd(13'd3, v); chk("R5 write held", v, 8'h00);
        wr(13'd0, 8'h00);
        wr(13'd3, 8'h07); rd(13'd3, v); chk("R5 released", v, 8'h07);
    endtask

    task automatic t_abort();
        logic [7:0] v;
        send_instr(1'b0, 13'd3);
        for (int i = 0; i < 3; i++) begin
            mosi = 1'b1; half(); sclk = 1'b1; half(); sclk = 1'b0;
        end
        half(); cs_n = 1'b1; half();
        rd(13'd3, v); chk("R9 abort no write", v, 8'h07);
        wr(13'd3, 8'h0C); rd(13'd3, v); chk("R9 next transfer ok", v, 8'h0C);
    endtask

    task automatic t_powerdown();
        logic [7:0] v;
        wr(13'd1, 8'h20);
        chk("R10 pwr_down pin", {7'd0, pwr_down}, 8'h01);
        wr(13'd3, 8'h09); rd(13'd3, v); chk("R10 access while down", v, 8'h09);
        wr(13'd1, 8'h00);
        chk("R10 pwr_down cleared", {7'd0, pwr_down}, 8'h00);
    endtask

    initial begin
        repeat (4) @(negedge clk);
        rst_n = 1'b1;
        repeat (4) @(negedge clk);
        t_reset();
        t_write_read();
        t_status();
        t_unmapped();
        t_lsb();
        t_long();
        t_softreset();
        t_abort();
        t_powerdown();
        if (!finished) begin
            finished = 1;
            $display("Simulation finished: %0d checks, %0d errors", checks, errors);
            $finish;
        end
    end

    initial begin
        repeat (200000) @(posedge clk);
        if (!finished) begin
            finished = 1;
            checks++; errors++;
            $display("FAIL watchdog: got timeout expected completion");
            $display("Simulation finished: %0d checks, %0d errors", checks, errors);
            $finish;
        end
    end
endmodule